// File: doc/BRIEF.md
# Fan Drive Setting Register with PWM Generator

This block keeps an 8-bit drive setting for each fan channel and turns it into a PWM waveform. The setting has two possible owners. Two automatic sources, a closed-loop speed controller and a temperature lookup table, arrive as input words with their own enable bits. While either source is enabled it owns the channel. The register then follows the source's word every cycle, and host writes are dropped. When both sources are off, the register keeps the last value it held and becomes host-writable.

A host read always returns the value the driver is actually using, which is not necessarily the last value written. One channel can be given up to general-purpose I/O. In that mode its setting reads as zero and its PWM pin stays low. Each channel also has a clock divide register that sets the PWM tick rate. A new setting is taken up only at the boundary of a PWM period, so no pulse is ever cut short.

Top module: `fan_drive_ctl`

## Requirements
- R1: After reset every setting reads 00h, every divide register reads 01h, and every PWM output is low.
- R2: While a channel's speed-controller enable or lookup-table enable is high, a read of that channel's setting returns the automatic word, from two cycles after the enable rises. If both enables are high, the speed-controller word wins.
- R3: With both automatic enables of a channel low, a host write to the setting field (field code 0) is stored and read back. When the automatic sources turn off, the register keeps the last automatic word it held.
- R4: A host write to the setting field while either automatic enable of that channel is high leaves the setting unchanged.
- R5: The PWM period is 255 ticks. The output is high for the first S ticks of each period, where S is the setting, so the duty cycle is S/255.
- R6: The divide field (field code 1) stores 8 bits and sets one tick per D clock cycles. A stored value of 0 behaves as 1 and still reads back as 0.
- R7: While the aux GPIO mode input is high, the setting of channel index GPIO_CH reads 00h and that channel's PWM output stays low.
- R8: A changed setting takes effect only at the start of the next PWM period. The period that is already running keeps its old high time.
- R9: A setting of 00h keeps the output low for whole periods, and FFh keeps it high for whole periods.
- R10: The rd_valid output and rd_data appear exactly one cycle after rd_en, for the channel in rd_sel and the field in rd_reg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_sel | input | SEL_W | Channel addressed by the write |
| host_wr_reg | input | 1 | Field written: 0 setting, 1 divide |
| host_wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | SEL_W | Channel addressed by the read |
| rd_reg | input | 1 | Field read: 0 setting, 1 divide |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Read data |
| alg_en | input | NUM_CH | Speed-controller ownership per channel |
| alg_setting | input | NUM_CH*8 | Speed-controller words, channel 0 in the low byte |
| lut_en | input | NUM_CH | Lookup-table ownership per channel |
| lut_setting | input | NUM_CH*8 | Lookup-table words, channel 0 in the low byte |
| aux_gpio_mode | input | 1 | Gives channel GPIO_CH up to general I/O |
| pwm_out | output | NUM_CH | Registered PWM outputs |

## Verification
The bench uses the default build: two channels, with GPIO_CH set to 1. This lets it compare a channel in GPIO mode against a channel that keeps driving. Because the period is fixed at 255 ticks, high-time counts at divide values 1, 2 and 0 finish within a few hundred cycles each. Those counts expose the tick scaling, the divide-by-zero rule and the deferred update within one period.

// File: rtl/fan_drive_pkg.sv
package fan_drive_pkg;
  localparam int SET_W = 8;
  typedef logic [SET_W-1:0] drive_t;
  typedef enum logic {
    FLD_SETTING = 1'b0,
    FLD_DIVIDE  = 1'b1
  } fan_field_e;
  localparam drive_t SET_RESET = 8'h00;
  localparam drive_t DIV_RESET = 8'h01;
endpackage

// File: rtl/fan_setting_reg.sv
module fan_setting_reg
  import fan_drive_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_set,
  input  logic   wr_div,
  input  drive_t wr_data,
  input  logic   alg_en,
  input  drive_t alg_val,
  input  logic   lut_en,
  input  drive_t lut_val,
  output drive_t setting_o,
  output drive_t divide_o
);
  logic   auto_on;
  drive_t auto_val;
  drive_t set_q;
  drive_t div_q;

  // the speed controller has priority over the table when both own the channel
  always_comb begin
    auto_on  = alg_en | lut_en;
    auto_val = alg_en ? alg_val : lut_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q <= SET_RESET;
      div_q <= DIV_RESET;
    end else begin
      if (auto_on)     set_q <= auto_val;
      else if (wr_set) set_q <= wr_data;
      if (wr_div)      div_q <= wr_data;
    end
  end

  assign setting_o = set_q;
  assign divide_o  = div_q;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_drive_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   drive_en,
  input  drive_t setting,
  input  drive_t divide,
  output logic   pwm_o,
  output drive_t duty_o,
  output logic   wrap_o
);
  localparam drive_t CNT_LAST = drive_t'((1 << SET_W) - 2);

  drive_t pre_q, cnt_q, duty_q;
  drive_t div_eff, cnt_nxt, duty_nxt;
  logic   tick, wrap;

  always_comb begin
    div_eff  = (divide == '0) ? drive_t'(1) : divide;
    tick     = (pre_q >= div_eff - drive_t'(1));
    wrap     = tick && (cnt_q == CNT_LAST);
    if (wrap)      cnt_nxt = '0;
    else if (tick) cnt_nxt = cnt_q + drive_t'(1);
    else           cnt_nxt = cnt_q;
    duty_nxt = wrap ? setting : duty_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      duty_q <= SET_RESET;
      pwm_o  <= 1'b0;
    end else begin
      pre_q  <= tick ? '0 : pre_q + drive_t'(1);
      cnt_q  <= cnt_nxt;
      duty_q <= duty_nxt;
      pwm_o  <= drive_en && (cnt_nxt < duty_nxt);
    end
  end

  assign duty_o = duty_q;
  assign wrap_o = wrap;
endmodule

// File: rtl/fan_drive_ctl.sv
module fan_drive_ctl
  import fan_drive_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int GPIO_CH = 1,
  localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_wr_en,
  input  logic [SEL_W-1:0]      host_wr_sel,
  input  logic                  host_wr_reg,
  input  logic [SET_W-1:0]      host_wr_data,
  input  logic                  rd_en,
  input  logic [SEL_W-1:0]      rd_sel,
  input  logic                  rd_reg,
  output logic                  rd_valid,
  output logic [SET_W-1:0]      rd_data,
  input  logic [NUM_CH-1:0]     alg_en,
  input  logic [NUM_CH*SET_W-1:0] alg_setting,
  input  logic [NUM_CH-1:0]     lut_en,
  input  logic [NUM_CH*SET_W-1:0] lut_setting,
  input  logic                  aux_gpio_mode,
  output logic [NUM_CH-1:0]     pwm_out
);
  logic [NUM_CH*SET_W-1:0] set_flat, div_flat, duty_flat;
  logic [NUM_CH-1:0]       wrap_vec, gpio_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit         = host_wr_en && (host_wr_sel == SEL_W'(c));
    assign gpio_vec[c] = (c == GPIO_CH) ? aux_gpio_mode : 1'b0;

    fan_setting_reg u_reg (
      .clk       (clk),
      .rst       (rst),
      .wr_set    (hit && (host_wr_reg == FLD_SETTING)),
      .wr_div    (hit && (host_wr_reg == FLD_DIVIDE)),
      .wr_data   (host_wr_data),
      .alg_en    (alg_en[c]),
      .alg_val   (alg_setting[c*SET_W +: SET_W]),
      .lut_en    (lut_en[c]),
      .lut_val   (lut_setting[c*SET_W +: SET_W]),
      .setting_o (set_flat[c*SET_W +: SET_W]),
      .divide_o  (div_flat[c*SET_W +: SET_W])
    );

    fan_pwm_gen u_pwm (
      .clk      (clk),
      .rst      (rst),
      .drive_en (!gpio_vec[c]),
      .setting  (set_flat[c*SET_W +: SET_W]),
      .divide   (div_flat[c*SET_W +: SET_W]),
      .pwm_o    (pwm_out[c]),
      .duty_o   (duty_flat[c*SET_W +: SET_W]),
      .wrap_o   (wrap_vec[c])
    );
  end

  drive_t rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_sel == SEL_W'(c)) begin
        if (rd_reg == FLD_DIVIDE)  rd_mux = div_flat[c*SET_W +: SET_W];
        else if (gpio_vec[c])      rd_mux = '0;
        else                       rd_mux = set_flat[c*SET_W +: SET_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/fan_drive_ctl_chk.sv
module fan_drive_ctl_chk
  import fan_drive_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int GPIO_CH = 1,
  parameter int SEL_W   = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    host_wr_en,
  input logic [SEL_W-1:0]        host_wr_sel,
  input logic                    host_wr_reg,
  input logic [SET_W-1:0]        host_wr_data,
  input logic                    rd_en,
  input logic [SEL_W-1:0]        rd_sel,
  input logic                    rd_reg,
  input logic                    rd_valid,
  input logic [SET_W-1:0]        rd_data,
  input logic [NUM_CH-1:0]       alg_en,
  input logic [NUM_CH*SET_W-1:0] alg_setting,
  input logic [NUM_CH-1:0]       lut_en,
  input logic                    aux_gpio_mode,
  input logic [NUM_CH-1:0]       pwm_out,
  input logic [NUM_CH*SET_W-1:0] set_flat,
  input logic [NUM_CH*SET_W-1:0] duty_flat,
  input logic [NUM_CH-1:0]       wrap_vec
);
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R10

  AST_GPIO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == SEL_W'(GPIO_CH) && rd_reg == 1'b0 && aux_gpio_mode) |=> rd_data == '0); // R7

  AST_GPIO_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(aux_gpio_mode) |-> !pwm_out[GPIO_CH]); // R7

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_HOST_WR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (host_wr_en && host_wr_sel == SEL_W'(c) && host_wr_reg == 1'b0 && !alg_en[c] && !lut_en[c])
      |=> set_flat[c*SET_W +: SET_W] == $past(host_wr_data)); // R3

    AST_ALG_OWNS: assert property (@(posedge clk) disable iff (rst)
      alg_en[c] |=> set_flat[c*SET_W +: SET_W] == $past(alg_setting[c*SET_W +: SET_W])); // R4

    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wrap_vec[c] |=> $stable(duty_flat[c*SET_W +: SET_W])); // R8

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
      (duty_flat[c*SET_W +: SET_W] == 8'h00) |-> !pwm_out[c]); // R9

    if (c != GPIO_CH) begin : g_full
      AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (duty_flat[c*SET_W +: SET_W] == 8'hFF) |-> pwm_out[c]); // R9
    end
  end
endmodule

bind fan_drive_ctl fan_drive_ctl_chk #(
  .NUM_CH(NUM_CH), .GPIO_CH(GPIO_CH), .SEL_W(SEL_W)
) chk_i (.*);

// File: tb/fan_drive_ctl_tb_top.sv
module fan_drive_ctl_tb_top;
  localparam int NUM_CH = 2;
  localparam int SEL_W  = 1;
  localparam int PER    = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr_en = 1'b0;
  logic [SEL_W-1:0] host_wr_sel = '0;
  logic host_wr_reg = 1'b0;
  logic [7:0] host_wr_data = '0;
  logic rd_en = 1'b0;
  logic [SEL_W-1:0] rd_sel = '0;
  logic rd_reg = 1'b0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic [NUM_CH-1:0] alg_en = '0, lut_en = '0;
  logic [NUM_CH*8-1:0] alg_setting = '0, lut_setting = '0;
  logic aux_gpio_mode = 1'b0;
  logic [NUM_CH-1:0] pwm_out;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  fan_drive_ctl #(.NUM_CH(NUM_CH), .GPIO_CH(1)) dut_i (.*);

  task automatic note(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input bit fld, input logic [7:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_sel = SEL_W'(ch); host_wr_reg = fld; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  // driver: issue a read and push the expected value to the scoreboard
  task automatic rd(input int ch, input bit fld, input logic [7:0] e, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = SEL_W'(ch); rd_reg = fld;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compare each valid read against the oldest expected item
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) note(1'b0, "R10 unexpected rd_valid", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        note(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count high cycles over one period starting at a rising edge
  task automatic measure(input int ch, input int cyc, input int exp, input string req,
                         input bool_dummy = 0);
    logic prev;
    int hi;
    prev = pwm_out[ch];
    do begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) break;
      prev = pwm_out[ch];
    end while (1);
    hi = 1;
    for (int i = 1; i < cyc; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
    note(hi == exp, req, hi, exp);
  endtask

  task automatic hold(input int ch, input int n, input logic v, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch] !== v) bad++;
    end
    note(bad == 0, req, bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    note(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    note(pwm_out == '0, "R1 pwm low", pwm_out, 0);
    rd(0, 0, 8'h00, "R1 set0");
    rd(1, 0, 8'h00, "R1 set1");
    rd(0, 1, 8'h01, "R1 div0");
    rd(1, 1, 8'h01, "R1 div1");
    // R3 host write, R5 duty
    wr(0, 0, 8'h40);
    rd(0, 0, 8'h40, "R3 readback");
    idle(2 * PER);
    measure(0, PER, 64, "R5 duty 40h");
    // R8 change mid-period keeps old high time, then applies
    begin
      logic prev;
      int hi;
      prev = pwm_out[0];
      do begin @(negedge clk); if (!prev && pwm_out[0]) break; prev = pwm_out[0]; end while (1);
      hi = 1;
      for (int i = 1; i < PER; i++) begin
        @(negedge clk);
        host_wr_en = (i == 5); host_wr_sel = 0; host_wr_reg = 0; host_wr_data = 8'h80;
        if (pwm_out[0]) hi++;
      end
      host_wr_en = 1'b0;
      note(hi == 64, "R8 old period kept", hi, 64);
    end
    measure(0, PER, 128, "R5 duty 80h");
    // R2/R4 automatic ownership
    alg_setting[7:0] = 8'h33; lut_setting[7:0] = 8'h55;
    alg_en[0] = 1'b1; idle(2);
    wr(0, 0, 8'h99);
    rd(0, 0, 8'h33, "R4 write dropped alg");
    alg_en[0] = 1'b0; lut_en[0] = 1'b1; idle(2);
    wr(0, 0, 8'h99);
    rd(0, 0, 8'h55, "R2 lut live");
    alg_en[0] = 1'b1; idle(2);
    rd(0, 0, 8'h33, "R2 alg priority");
    alg_en[0] = 1'b0; lut_en[0] = 1'b0; idle(2);
    rd(0, 0, 8'h33, "R3 keeps last");
    wr(0, 0, 8'h22);
    rd(0, 0, 8'h22, "R3 write after release");
    // R7 gpio mode on channel 1
    wr(1, 0, 8'h10);
    rd(1, 0, 8'h10, "R3 ch1 write");
    aux_gpio_mode = 1'b1; idle(2);
    rd(1, 0, 8'h00, "R7 reads zero");
    rd(0, 0, 8'h22, "R7 ch0 unaffected");
    hold(1, 300, 1'b0, "R7 pin low");
    aux_gpio_mode = 1'b0; idle(2);
    rd(1, 0, 8'h10, "R7 restored");
    // R9 extremes
    wr(0, 0, 8'hFF); idle(2 * PER);
    hold(0, 300, 1'b1, "R9 FFh high");
    wr(0, 0, 8'h00); idle(2 * PER);
    hold(0, 300, 1'b0, "R9 00h low");
    // R6 divide
    wr(0, 0, 8'h40);
    wr(0, 1, 8'h02);
    rd(0, 1, 8'h02, "R6 div readback");
    idle(3 * 2 * PER);
    measure(0, 2 * PER, 128, "R6 divide 2");
    wr(0, 1, 8'h00);
    rd(0, 1, 8'h00, "R6 div zero stored");
    idle(3 * PER);
    measure(0, PER, 64, "R6 divide 0 as 1");
    idle(3);
    note(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule